// File: doc/BRIEF.md
# Nonvolatile Memory Command Timer

This block sets the duration of program and erase operations in an on-chip nonvolatile memory controller. Software sets a clock divider once, normally during start-up. The divided value defines a slow timing period of (divider + 1) bus cycles. Each accepted command then holds the busy output for a fixed number of those periods, and the block marks completion with a one-cycle done pulse.

Four operations are supported: a single-byte program, a burst program, a page erase and a whole-array erase. A burst program only runs at its shorter length when it is chained directly onto a finishing program operation. An access-error flag records a command started before the divider was set, and a command started while the block is busy. While this flag is set, the divider register is locked. The memory array, the high-voltage control, and address or data storage sit outside this block.

Top module: `nvm_cmd_timer`

## Requirements
- R1: After reset, busy, done and acc_err are all low.
- R2: A cmd_start before the divider has been written is rejected: acc_err rises on the next cycle and busy stays low.
- R3: The divider accepts only its first successful write. Every later div_wr is ignored and the period length does not change.
- R4: A div_wr while acc_err is high is ignored and does not count as the one allowed write.
- R5: An err_clr pulse clears acc_err on the next cycle. If a rejected cmd_start occurs in the same cycle, the flag stays set.
- R6: One timing period lasts (divider + 1) bus cycles. Busy rises in the cycle after an accepted cmd_start and stays high for exactly N × (divider + 1) cycles, where N is the period count of the operation.
- R7: cmd_op = 2'b00 (byte program) lasts PROG_CYC periods (default 9).
- R8: cmd_op = 2'b01 (burst program) lasts BURST_CYC periods (default 4) when it is started in the cycle where done pulses for a finishing 2'b00 or 2'b01 operation. Otherwise it lasts PROG_CYC periods.
- R9: cmd_op = 2'b10 (page erase) lasts PAGE_CYC periods (default 4000).
- R10: cmd_op = 2'b11 (mass erase) lasts MASS_CYC periods (default 20000).
- R11: done pulses high for exactly one cycle, in the cycle right after the last busy cycle. Busy is low in that cycle, so a new command can be started in it.
- R12: A cmd_start while busy is high sets acc_err on the next cycle and is otherwise ignored. The running operation keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_wr | input | 1 | Divider write strobe |
| div_val | input | DIV_W | Divider value to write |
| err_clr | input | 1 | Write-one strobe that clears acc_err |
| cmd_start | input | 1 | Command start strobe |
| cmd_op | input | 2 | Operation: 00 byte program, 01 burst program, 10 page erase, 11 mass erase |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_err | output | 1 | Access-error flag |

## Verification
The properties assume that cmd_start, div_wr and err_clr are single-cycle strobes sampled on the rising edge. They also assume that err_clr is not asserted in the same cycle as a rejected start unless that overlap is the case under test. The bench drives every strobe on the falling edge for one cycle only. It issues overlapping err_clr and start pulses in just one deliberate step. The bench sweeps several divider values, each after a fresh reset. It uses short erase counts so that every operation type and every chaining case completes within each sweep point.

// File: rtl/nvm_tmr_pkg.sv
package nvm_tmr_pkg;

    // Operation codes carried on cmd_op
    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_BURST = 2'b01,
        OP_PAGE  = 2'b10,
        OP_MASS  = 2'b11
    } nvm_op_e;

endpackage

// File: rtl/nvm_tmr_div_reg.sv
// Write-once divider register with a lock bit.
module nvm_tmr_div_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] div,
    output logic         locked
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         lock;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !st_q.lock) begin
            st_d.val  = wr_data;
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div    = st_q.val;
    assign locked = st_q.lock;

endmodule

// File: rtl/nvm_tmr_prescale.sv
// Timing-period enable: one tick every (div + 1) cycles while running.
module nvm_tmr_prescale #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       tick_c;

    always_comb begin
        st_d   = st_q;
        tick_c = run && !restart && (st_q.cnt == '0);
        if (restart) begin
            st_d.cnt = div;
        end else if (tick_c) begin
            st_d.cnt = div;
        end else if (run) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = tick_c;

endmodule

// File: rtl/nvm_tmr_period_cnt.sv
// Counts timing periods down from a loaded value; flags the final tick.
module nvm_tmr_period_cnt #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          last
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } per_state_t;

    per_state_t st_d, st_q;
    logic       last_c;

    always_comb begin
        st_d   = st_q;
        last_c = tick && (st_q.cnt == '0);
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last = last_c;

endmodule

// File: rtl/nvm_cmd_timer.sv
// Program/erase command timer top level.
module nvm_cmd_timer #(
    parameter int DIV_W     = 6,
    parameter int PROG_CYC  = 9,
    parameter int BURST_CYC = 4,
    parameter int PAGE_CYC  = 4000,
    parameter int MASS_CYC  = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             err_clr,
    input  logic             cmd_start,
    input  logic [1:0]       cmd_op,
    output logic             busy,
    output logic             done,
    output logic             acc_err
);

    import nvm_tmr_pkg::*;

    localparam int MAX_AB  = (PROG_CYC > BURST_CYC) ? PROG_CYC : BURST_CYC;
    localparam int MAX_CD  = (PAGE_CYC > MASS_CYC) ? PAGE_CYC : MASS_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        logic busy;
        logic done;
        logic err;
        logic prog;
    } ctl_state_t;

    ctl_state_t       ctl_d, ctl_q;
    logic [DIV_W-1:0] div_cur;
    logic             div_locked;
    logic             div_wr_ok;
    logic             tick;
    logic             last;
    logic             accept;
    logic             rejected;
    logic             finish;
    logic             chain;
    logic [CNT_W-1:0] load_val;
    nvm_op_e          op;

    assign div_wr_ok = div_wr && !ctl_q.err;

    nvm_tmr_div_reg #(.W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (div_wr_ok),
        .wr_data (div_val),
        .div     (div_cur),
        .locked  (div_locked)
    );

    nvm_tmr_prescale #(.W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (ctl_q.busy),
        .div     (div_cur),
        .tick    (tick)
    );

    nvm_tmr_period_cnt #(.CW(CNT_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .tick     (tick),
        .last     (last)
    );

    always_comb begin
        op       = nvm_op_e'(cmd_op);
        accept   = cmd_start && div_locked && !ctl_q.busy;
        rejected = cmd_start && (!div_locked || ctl_q.busy);
        finish   = ctl_q.busy && last;
        chain    = ctl_q.done && ctl_q.prog;

        unique case (op)
            OP_PROG:  load_val = CNT_W'(PROG_CYC - 1);
            OP_BURST: load_val = chain ? CNT_W'(BURST_CYC - 1) : CNT_W'(PROG_CYC - 1);
            OP_PAGE:  load_val = CNT_W'(PAGE_CYC - 1);
            default:  load_val = CNT_W'(MASS_CYC - 1);
        endcase

        ctl_d      = ctl_q;
        ctl_d.done = finish;
        if (accept) begin
            ctl_d.busy = 1'b1;
            ctl_d.prog = (op == OP_PROG) || (op == OP_BURST);
        end else if (finish) begin
            ctl_d.busy = 1'b0;
        end

        if (rejected) begin
            ctl_d.err = 1'b1;
        end else if (err_clr) begin
            ctl_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = ctl_q.busy;
    assign done    = ctl_q.done;
    assign acc_err = ctl_q.err;

endmodule

// File: rtl/nvm_cmd_timer_chk.sv
module nvm_cmd_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic err_clr,
    input logic busy,
    input logic done,
    input logic acc_err,
    input logic div_locked
);

    // R11
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R11
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && busy) |=> acc_err);

    // R2
    nocfg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !div_locked) |=> (acc_err && !busy));

    // R5
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !cmd_start) |=> !acc_err);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_locked |=> div_locked);

endmodule

bind nvm_cmd_timer nvm_cmd_timer_chk u_chk (.*);

// File: tb/nvm_cmd_timer_test.sv
module nvm_cmd_timer_test;

    localparam int DW    = 6;
    localparam int PROG  = 9;
    localparam int BURST = 4;
    localparam int PAGE  = 40;
    localparam int MASS  = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          div_wr = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic          err_clr = 1'b0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic          busy, done, acc_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    nvm_cmd_timer #(
        .DIV_W(DW), .PROG_CYC(PROG), .BURST_CYC(BURST),
        .PAGE_CYC(PAGE), .MASS_CYC(MASS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val),
        .err_clr(err_clr), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .busy(busy), .done(done), .acc_err(acc_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue a command at the current falling edge and count busy cycles.
    task automatic run_cmd(input logic [1:0] op, input bit poke, output int n);
        cmd_start = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_start = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 1) begin
                cmd_start = 1'b1;
                cmd_op    = 2'b11;
            end else begin
                cmd_start = 1'b0;
            end
            @(negedge clk);
        end
        cmd_start = 1'b0;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic write_div(input logic [DW-1:0] v);
        div_wr  = 1'b1;
        div_val = v;
        @(negedge clk);
        div_wr  = 1'b0;
    endtask

    initial begin
        int dl [9] = '{0, 1, 2, 3, 4, 5, 6, 7, 63};
        int n;
        foreach (dl[i]) begin
            int d = dl[i];
            int p = d + 1;
            logic [DW-1:0] other = DW'(d ^ 5);

            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1
            chk(!busy && !done && !acc_err, "R1 reset outputs", {busy, done, acc_err}, 0);

            // R2: command before divider written
            cmd_start = 1'b1; cmd_op = 2'b00;
            @(negedge clk);
            cmd_start = 1'b0;
            chk(acc_err && !busy, "R2 unconfigured start", {acc_err, busy}, 2);

            // R5: clear with simultaneous rejected start keeps flag
            err_clr = 1'b1; cmd_start = 1'b1;
            @(negedge clk);
            err_clr = 1'b0; cmd_start = 1'b0;
            chk(acc_err, "R5 set wins over clear", acc_err, 1);

            // R4: divider write while flag set is ignored
            write_div(other);

            pulse_clr();
            chk(!acc_err, "R5 clear", acc_err, 0);

            write_div(DW'(d));
            // R3: second write ignored
            write_div(other);

            run_cmd(2'b00, 1'b0, n);
            chk(n == PROG * p, "R7 R3 R4 R6 byte program", n, PROG * p);
            chk(done && !busy, "R11 done after program", {done, busy}, 2);

            run_cmd(2'b01, 1'b0, n);
            chk(n == BURST * p, "R8 chained burst", n, BURST * p);
            run_cmd(2'b01, 1'b0, n);
            chk(n == BURST * p, "R8 burst after burst", n, BURST * p);
            chk(done, "R11 done after burst", done, 1);
            @(negedge clk);
            chk(!done && !busy, "R11 done single pulse", {done, busy}, 0);

            run_cmd(2'b01, 1'b0, n);
            chk(n == PROG * p, "R8 unchained burst", n, PROG * p);

            run_cmd(2'b10, 1'b1, n);
            chk(n == PAGE * p, "R9 R12 page erase", n, PAGE * p);
            chk(acc_err, "R12 start while busy", acc_err, 1);

            run_cmd(2'b01, 1'b0, n);
            chk(n == PROG * p, "R8 burst after erase", n, PROG * p);
            pulse_clr();

            run_cmd(2'b11, 1'b0, n);
            chk(n == MASS * p, "R10 mass erase", n, MASS * p);
            chk(done && !acc_err, "R11 done after mass", {done, acc_err}, 2);
            @(negedge clk);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule